// File: doc/BRIEF.md
# Host/DSP Mailbox with Semaphore Set

This block passes short messages between a host processor and a DSP. It holds three message channels. In each channel the host posts a command word and the DSP fetches it, and the DSP posts a reply word and the host collects it. Each channel has two handshake flags that the host reads in a status word. The flags use inverted polarity: a flag reads 0 once the awaited event has happened and 1 while it is still outstanding.

Next to the channels sits a set of 16 semaphore flags. The DSP raises them and the host lowers them with a write-one-to-clear register. The host also has a mask that keeps chosen flags out of the interrupt. One host interrupt line combines the semaphore events with the reply events that the configuration word enables.

Both sides see simple synchronous register buses with single-cycle write and read strobes. Read data is combinational on the address, and every state change takes effect at the next clock edge. The two buses share one clock.

Top module: `dsp_mailbox`

## Requirements
- R1: After reset, command words, reply words, config, mask and semaphore flags are all 0. Status reads 16'hFC00: bits 15..10 are 1 and bit 9 is 0. host_irq is low.
- R2: A host write to command channel i (host offsets 0x20, 0x28, 0x30 for i = 0, 1, 2) stores the word. The DSP reads it at dsp_addr = i, and the host reads it back at the same offset. The write sets status bit 13+i to 1.
- R3: A DSP read strobe at dsp_addr = i sets status bit 13+i to 0. If the host writes that command in the same cycle, the bit ends at 1.
- R4: A DSP write at dsp_addr = i stores reply i and sets status bit 10+i to 0. The host reads reply i at offsets 0x24, 0x2C, 0x34, and a host write to those offsets has no effect.
- R5: A host read strobe on reply i sets status bit 10+i back to 1. A DSP write to that reply in the same cycle wins and leaves the bit at 0.
- R6: Config (host offset 0x00, 16-bit read/write) bits 9+i enable an interrupt for reply i. The interrupt is raised while status bit 10+i is 0 and config bit 9+i is 1.
- R7: A DSP write at dsp_addr = 3 sets each semaphore flag whose data bit is 1 and leaves the rest unchanged. The host reads the flags at offset 0x08, and a DSP read at dsp_addr = 3 also returns them.
- R8: A host write to offset 0x10 clears each flag whose data bit is 1 and leaves the flags written with 0 unchanged. When the DSP sets and the host clears the same flag in one cycle, the flag ends set.
- R9: Status bit 9 is 1 when some set flag has a 0 in the mask register (offset 0x0C, 1 = disabled). That condition drives host_irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both buses |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (acknowledges reply words) |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational on host_addr |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_rd | input | 1 | DSP read strobe (consumes command words) |
| dsp_addr | input | 2 | DSP index: 0..2 channels, 3 semaphore set |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data, combinational on dsp_addr |
| host_irq | output | 1 | Host interrupt request |

## Verification
The bench builds the block with its default parameters: three channels, 16-bit words and 16 semaphore flags. With these values every handshake bit of the status word and every reply enable bit of the config word can be reached. The semaphore tests use both end flags, bit 0 and bit 15, so the full set, mask and clear width is covered. The tests drive both buses in the same cycle to force the collisions where one side must win: a host command write against a DSP command read, a host reply read against a DSP reply write, and a semaphore set against a clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_CH  = 3;
    localparam int SEM_W   = 16;
    localparam int HADDR_W = 6;
    localparam int DADDR_W = $clog2(NUM_CH + 1);
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    // host byte offsets
    localparam int unsigned OFF_CFG   = 32'h00;
    localparam int unsigned OFF_STAT  = 32'h04;
    localparam int unsigned OFF_SEM   = 32'h08;
    localparam int unsigned OFF_MASK  = 32'h0C;
    localparam int unsigned OFF_CLR   = 32'h10;
    localparam int unsigned OFF_CH0   = 32'h20;
    localparam int unsigned CH_STRIDE = 8;
    localparam int unsigned OFF_CHEND = OFF_CH0 + NUM_CH * CH_STRIDE;

    // bit positions decoded by host software
    localparam int ST_SEM_BIT  = 9;
    localparam int CFG_IRQ_LSB = 9;

    // DSP index of the semaphore set register
    localparam int unsigned DSP_SEM_IDX = NUM_CH;

    typedef enum logic [2:0] {
        HR_NONE, HR_CFG, HR_STAT, HR_SEM, HR_MASK, HR_CLR, HR_CMD, HR_REP
    } hreg_e;

    typedef struct packed {
        hreg_e            kind;
        logic [CH_W-1:0]  ch;
    } hdec_t;

    typedef struct packed {
        logic [NUM_CH-1:0]     cmd_pend;   // 1 = DSP has not fetched
        logic [NUM_CH-1:0]     rep_idle;   // 1 = DSP has not posted
        logic                  sem_pend;
        logic [ST_SEM_BIT-1:0] rsvd;
    } status_t;

    function automatic hdec_t decode_host(input logic [HADDR_W-1:0] a);
        hdec_t       d;
        int unsigned ai;
        int unsigned off;
        ai     = 32'(a);
        d.kind = HR_NONE;
        d.ch   = '0;
        if (ai == OFF_CFG)       d.kind = HR_CFG;
        else if (ai == OFF_STAT) d.kind = HR_STAT;
        else if (ai == OFF_SEM)  d.kind = HR_SEM;
        else if (ai == OFF_MASK) d.kind = HR_MASK;
        else if (ai == OFF_CLR)  d.kind = HR_CLR;
        else if (ai >= OFF_CH0 && ai < OFF_CHEND && a[1:0] == 2'b00) begin
            off    = ai - OFF_CH0;
            d.ch   = CH_W'(off / CH_STRIDE);
            d.kind = ((off % CH_STRIDE) == 0) ? HR_CMD : HR_REP;
        end
        return d;
    endfunction

endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_cmd_we,
    input  logic         host_rep_re,
    input  logic [W-1:0] host_wdata,
    input  logic         dsp_cmd_re,
    input  logic         dsp_rep_we,
    input  logic [W-1:0] dsp_wdata,
    output logic [W-1:0] cmd_q,
    output logic [W-1:0] rep_q,
    output logic         cmd_pend,
    output logic         rep_idle
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            cmd_pend <= 1'b1;
        end else begin
            if (host_cmd_we) begin
                cmd_q    <= host_wdata;
                cmd_pend <= 1'b1;          // host posting outranks a fetch
            end else if (dsp_cmd_re) begin
                cmd_pend <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_q    <= '0;
            rep_idle <= 1'b1;
        end else begin
            if (dsp_rep_we) begin
                rep_q    <= dsp_wdata;
                rep_idle <= 1'b0;          // fresh reply outranks an ack
            end else if (host_rep_re) begin
                rep_idle <= 1'b1;
            end
        end
    end

    assert_cmd_post_R2: assert property (@(posedge clk) disable iff (rst)
        host_cmd_we |=> (cmd_pend && cmd_q == $past(host_wdata)));
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !host_cmd_we |=> $stable(cmd_q));
    assert_cmd_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (dsp_cmd_re && !host_cmd_we) |=> !cmd_pend);
    assert_rep_post_R4: assert property (@(posedge clk) disable iff (rst)
        dsp_rep_we |=> (!rep_idle && rep_q == $past(dsp_wdata)));
    assert_rep_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (host_rep_re && !dsp_rep_we) |=> rep_idle);

endmodule

// File: rtl/mbx_sema.sv
module mbx_sema
    import mbx_pkg::*;
#(
    parameter int N = SEM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic [N-1:0] set_bits,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_d,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         pending
);

    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;

    always_comb begin
        set_v = set_we ? set_bits : '0;
        clr_v = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            flags <= (flags & ~clr_v) | set_v;   // set beats clear
            if (mask_we) mask <= mask_d;
        end
    end

    assign pending = |(flags & ~mask);

    assert_sem_set_R7: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((flags & $past(set_bits)) == $past(set_bits)));
    assert_sem_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(flags));
    assert_sem_clr_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((flags & $past(clr_bits)) == '0));

endmodule

// File: rtl/dsp_mailbox.sv
module dsp_mailbox
    import mbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               dsp_wr,
    input  logic               dsp_rd,
    input  logic [DADDR_W-1:0] dsp_addr,
    input  logic [DATA_W-1:0]  dsp_wdata,
    output logic [DATA_W-1:0]  dsp_rdata,
    output logic               host_irq
);

    hdec_t              hdec;
    logic [DATA_W-1:0]  cfg_q;
    logic [DATA_W-1:0]  cmd_q [NUM_CH];
    logic [DATA_W-1:0]  rep_q [NUM_CH];
    logic [NUM_CH-1:0]  cmd_pend;
    logic [NUM_CH-1:0]  rep_idle;
    logic [NUM_CH-1:0]  rep_irq;
    logic [SEM_W-1:0]   sem_flags;
    logic [SEM_W-1:0]   sem_mask;
    logic               sem_pend;
    logic               dsp_sem_sel;
    status_t            stat;

    assign hdec        = decode_host(host_addr);
    assign dsp_sem_sel = (32'(dsp_addr) == DSP_SEM_IDX);

    always_ff @(posedge clk) begin
        if (rst)                                cfg_q <= '0;
        else if (host_wr && hdec.kind == HR_CFG) cfg_q <= host_wdata;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_h;
        logic sel_d;
        assign sel_h = (hdec.ch == CH_W'(c));
        assign sel_d = (dsp_addr == DADDR_W'(c));

        mbx_channel #(.W(DATA_W)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .host_cmd_we (host_wr && hdec.kind == HR_CMD && sel_h),
            .host_rep_re (host_rd && hdec.kind == HR_REP && sel_h),
            .host_wdata  (host_wdata),
            .dsp_cmd_re  (dsp_rd && sel_d),
            .dsp_rep_we  (dsp_wr && sel_d),
            .dsp_wdata   (dsp_wdata),
            .cmd_q       (cmd_q[c]),
            .rep_q       (rep_q[c]),
            .cmd_pend    (cmd_pend[c]),
            .rep_idle    (rep_idle[c])
        );

        assign rep_irq[c] = !rep_idle[c] && cfg_q[CFG_IRQ_LSB + c];
    end

    mbx_sema #(.N(SEM_W)) u_sema (
        .clk      (clk),
        .rst      (rst),
        .set_we   (dsp_wr && dsp_sem_sel),
        .set_bits (dsp_wdata),
        .clr_we   (host_wr && hdec.kind == HR_CLR),
        .clr_bits (host_wdata),
        .mask_we  (host_wr && hdec.kind == HR_MASK),
        .mask_d   (host_wdata),
        .flags    (sem_flags),
        .mask     (sem_mask),
        .pending  (sem_pend)
    );

    always_comb begin
        stat          = '0;
        stat.cmd_pend = cmd_pend;
        stat.rep_idle = rep_idle;
        stat.sem_pend = sem_pend;
    end

    always_comb begin
        host_rdata = '0;
        case (hdec.kind)
            HR_CFG:  host_rdata = cfg_q;
            HR_STAT: host_rdata = stat;
            HR_SEM:  host_rdata = sem_flags;
            HR_MASK: host_rdata = sem_mask;
            HR_CMD: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (hdec.ch == CH_W'(c)) host_rdata = cmd_q[c];
            end
            HR_REP: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (hdec.ch == CH_W'(c)) host_rdata = rep_q[c];
            end
            default: host_rdata = '0;
        endcase
    end

    always_comb begin
        dsp_rdata = '0;
        if (dsp_sem_sel) dsp_rdata = sem_flags;
        for (int c = 0; c < NUM_CH; c++)
            if (dsp_addr == DADDR_W'(c)) dsp_rdata = cmd_q[c];
    end

    assign host_irq = sem_pend | (|rep_irq);

    assert_irq_sem_R9: assert property (@(posedge clk) disable iff (rst)
        sem_pend |-> host_irq);
    assert_irq_rep_R6: assert property (@(posedge clk) disable iff (rst)
        (|rep_irq) |-> host_irq);
    assert_reset_flags_R1: assert property (@(posedge clk)
        $past(rst) |-> (&cmd_pend && &rep_idle && !host_irq));

endmodule

// File: tb/dsp_mailbox_tb_top.sv
module dsp_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        dsp_wr = 1'b0, dsp_rd = 1'b0;
    logic [1:0]  dsp_addr = '0;
    logic [15:0] dsp_wdata = '0;
    logic [15:0] dsp_rdata;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dsp_mailbox dut_i (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dsp_wr(dsp_wr), .dsp_rd(dsp_rd), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle on both sides, strobes released after the edge
    task automatic cyc(input logic hw, input logic hr, input logic [5:0] ha,
                       input logic [15:0] hd, input logic dw, input logic dr,
                       input logic [1:0] da, input logic [15:0] dd);
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
        dsp_wr = dw; dsp_rd = dr; dsp_addr = da; dsp_wdata = dd;
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0; dsp_wr = 1'b0; dsp_rd = 1'b0;
    endtask

    task automatic hpeek(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic dpeek(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        dsp_addr = a;
        #1 v = dsp_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        hpeek(6'h04, v); chk("R1 status", v, 16'hFC00);
        hpeek(6'h00, v); chk("R1 config", v, 16'h0000);
        hpeek(6'h08, v); chk("R1 sem flags", v, 16'h0000);
        hpeek(6'h0C, v); chk("R1 mask", v, 16'h0000);
        hpeek(6'h24, v); chk("R1 reply0", v, 16'h0000);
        chk("R1 irq", {15'b0, host_irq}, 16'h0000);
    endtask

    task automatic t_command();
        logic [15:0] v;
        cyc(1, 0, 6'h20, 16'hA5A5, 0, 0, 2'd0, 16'h0);
        dpeek(2'd0, v); chk("R2 dsp sees cmd0", v, 16'hA5A5);
        hpeek(6'h20, v); chk("R2 host readback cmd0", v, 16'hA5A5);
        hpeek(6'h04, v); chk("R2 cmd0 flag", v, 16'hFC00);
        cyc(1, 0, 6'h30, 16'h0F0F, 0, 0, 2'd0, 16'h0);
        dpeek(2'd2, v); chk("R2 dsp sees cmd2", v, 16'h0F0F);
        cyc(0, 0, 6'h00, 16'h0, 0, 1, 2'd0, 16'h0);
        hpeek(6'h04, v); chk("R3 cmd0 fetched", v, 16'hDC00);
        cyc(1, 0, 6'h20, 16'h1111, 0, 0, 2'd0, 16'h0);
        hpeek(6'h04, v); chk("R2 cmd0 reposted", v, 16'hFC00);
        cyc(1, 0, 6'h28, 16'h2222, 0, 1, 2'd1, 16'h0);
        hpeek(6'h04, v); chk("R3 host write wins", v, 16'hFC00);
        cyc(0, 0, 6'h00, 16'h0, 0, 1, 2'd1, 16'h0);
        hpeek(6'h04, v); chk("R3 cmd1 fetched", v, 16'hBC00);
        cyc(1, 0, 6'h28, 16'h3333, 0, 0, 2'd0, 16'h0);
    endtask

    task automatic t_reply();
        logic [15:0] v;
        cyc(0, 0, 6'h00, 16'h0, 1, 0, 2'd2, 16'h1234);
        hpeek(6'h04, v); chk("R4 reply2 flag", v, 16'hEC00);
        hpeek(6'h34, v); chk("R4 reply2 data", v, 16'h1234);
        cyc(1, 0, 6'h34, 16'hFFFF, 0, 0, 2'd0, 16'h0);
        hpeek(6'h34, v); chk("R4 host write ignored data", v, 16'h1234);
        hpeek(6'h04, v); chk("R4 host write ignored flag", v, 16'hEC00);
        cyc(0, 1, 6'h34, 16'h0, 0, 0, 2'd0, 16'h0);
        hpeek(6'h04, v); chk("R5 reply2 acked", v, 16'hFC00);
        cyc(0, 1, 6'h2C, 16'h0, 1, 0, 2'd1, 16'h5678);
        hpeek(6'h04, v); chk("R5 dsp write wins", v, 16'hF400);
        hpeek(6'h2C, v); chk("R4 reply1 data", v, 16'h5678);
        cyc(0, 1, 6'h2C, 16'h0, 0, 0, 2'd0, 16'h0);
        hpeek(6'h04, v); chk("R5 reply1 acked", v, 16'hFC00);
    endtask

    task automatic t_reply_irq();
        logic [15:0] v;
        cyc(1, 0, 6'h00, 16'h0400, 0, 0, 2'd0, 16'h0);
        hpeek(6'h00, v); chk("R6 config readback", v, 16'h0400);
        cyc(0, 0, 6'h00, 16'h0, 1, 0, 2'd0, 16'hBEEF);
        #1 chk("R6 disabled reply0 no irq", {15'b0, host_irq}, 16'h0000);
        cyc(0, 0, 6'h00, 16'h0, 1, 0, 2'd1, 16'hCAFE);
        #1 chk("R6 enabled reply1 irq", {15'b0, host_irq}, 16'h0001);
        cyc(0, 1, 6'h2C, 16'h0, 0, 0, 2'd0, 16'h0);
        #1 chk("R6 irq drops on ack", {15'b0, host_irq}, 16'h0000);
        cyc(1, 0, 6'h00, 16'h0200, 0, 0, 2'd0, 16'h0);
        #1 chk("R6 enable pending reply0", {15'b0, host_irq}, 16'h0001);
        cyc(0, 1, 6'h24, 16'h0, 0, 0, 2'd0, 16'h0);
        #1 chk("R6 irq clear after reply0 ack", {15'b0, host_irq}, 16'h0000);
    endtask

    task automatic t_sema();
        logic [15:0] v;
        cyc(0, 0, 6'h00, 16'h0, 1, 0, 2'd3, 16'h8001);
        hpeek(6'h08, v); chk("R7 flags set", v, 16'h8001);
        dpeek(2'd3, v); chk("R7 dsp reads flags", v, 16'h8001);
        hpeek(6'h04, v); chk("R9 pending bit", v, 16'hFE00);
        chk("R9 irq", {15'b0, host_irq}, 16'h0001);
        cyc(0, 0, 6'h00, 16'h0, 1, 0, 2'd3, 16'h0002);
        hpeek(6'h08, v); chk("R7 set keeps others", v, 16'h8003);
        cyc(1, 0, 6'h0C, 16'h8003, 0, 0, 2'd0, 16'h0);
        hpeek(6'h04, v); chk("R9 all masked", v, 16'hFC00);
        chk("R9 irq masked", {15'b0, host_irq}, 16'h0000);
        cyc(1, 0, 6'h0C, 16'h0003, 0, 0, 2'd0, 16'h0);
        chk("R9 bit15 unmasked", {15'b0, host_irq}, 16'h0001);
        cyc(1, 0, 6'h10, 16'h8000, 0, 0, 2'd0, 16'h0);
        hpeek(6'h08, v); chk("R8 clear bit15", v, 16'h0003);
        hpeek(6'h04, v); chk("R9 remaining masked", v, 16'hFC00);
        cyc(1, 0, 6'h10, 16'h0001, 0, 0, 2'd0, 16'h0);
        hpeek(6'h08, v); chk("R8 zero bits unchanged", v, 16'h0002);
        cyc(1, 0, 6'h10, 16'h0012, 1, 0, 2'd3, 16'h0010);
        hpeek(6'h08, v); chk("R8 set wins over clear", v, 16'h0010);
        hpeek(6'h04, v); chk("R9 bit4 pending", v, 16'hFE00);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_command();
        t_reply();
        t_reply_irq();
        t_sema();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule